// File: doc/BRIEF.md
# Memory Chip-Select and Wait-State Generator

This block watches every bus cycle on a 20-bit address bus and, for memory cycles, asserts one of six active-low chip selects. One select guards a region that ends at the highest address, and one guards a region that starts at address zero. The other four split a relocatable middle region into four equal sub-blocks. Bus cycles issued by the processor and by the DMA engine are decoded the same way. The block does not tell them apart.

Each region has its own wait-state count and its own choice of whether an external ready input must also be seen. The block pulses an internal ready toward the bus controller when the cycle may finish. It also latches address bits 1 and 2 at the address strobe, for peripherals that need them after the bus has moved on to data. A small write-only register port sets up the regions.

The cycle controller is a three-state machine:
- `S_IDLE`: no cycle is open and all selects are high.
- `S_WAIT`: a select is held low while the wait counter runs down and, if the region asks for it, external ready is awaited.
- `S_DONE`: internal ready is high for one clock while the select is still held.

Transitions:
- idle→wait: a strobe arrives for a memory cycle that hits a region.
- wait→wait: the count is not exhausted, or external ready is required and low.
- wait→done: the count is zero and ready is satisfied.
- done→idle: always, on the next clock.

Register map, selected by `cfg_addr`:
- 0: top region.
- 1: bottom region.
- 2: middle region control.
- 3: middle base.

The three control registers share one layout: bit 0 enable, bits 3:1 size code `k`, bits 5:4 wait count, bit 6 external-ready required. Register 3 holds address bits 19:12 of the middle base in `cfg_wdata[7:0]`.

Top module: `memcs_wait_unit`

## Requirements
- R1: After reset only the top region is enabled, with size 1 KB, 3 wait states and external ready required. The bottom and middle selects stay high, and internal ready stays low, until those regions are programmed.
- R2: The top region with size code k covers the last 1 KB·2^k of memory (k=0: FFC00h–FFFFFh). A memory cycle there drives `cs_top_n` low.
- R3: The bottom region with size code k covers 00000h up to 1 KB·2^k − 1. A memory cycle there drives `cs_bot_n` low.
- R4: The middle region with size code k spans 4 KB·2^k from its base. Sub-block i (i = 0..3) has size 1 KB·2^k, is selected by address bits [11+k:10+k], and drives `cs_mid_n[i]` low. An address one past the region selects nothing.
- R5: At most one select is low at any time. On overlap the top region wins over the bottom, and the bottom wins over the middle.
- R6: A select goes low on the clock after the strobe and stays low through the cycle. With wait count n and external ready ignored, `rdy_int` is high for exactly one clock, after n+1 clocks of the select being low. The select rises on the clock after that.
- R7: With external ready required, the clock on which `rdy_int` rises is the later of two events: the wait count running out, and the first clock edge that samples `ext_rdy` high. If ext_rdy is held low for the first L edges after the strobe, the select is low for max(n,L)+1 clocks before ready.
- R8: Non-memory cycles, memory cycles outside every enabled region, and cycles in a disabled region assert no select and no ready.
- R9: A strobe arriving while a cycle is open is ignored. The open cycle's select, timing and latched address bits are unchanged.
- R10: `lat_a1`/`lat_a2` take address bits 1 and 2 on a strobe accepted while idle, and hold them otherwise.
- R11: Register writes take effect for the next cycle. Clearing a region's enable bit removes its select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| ale | input | 1 | Address strobe marking the start of a bus cycle |
| mem_cycle | input | 1 | High for memory cycles, low for I/O |
| bus_addr | input | 20 | Bus cycle address, valid with `ale` |
| ext_rdy | input | 1 | External ready |
| cs_top_n | output | 1 | Top region select, active low |
| cs_bot_n | output | 1 | Bottom region select, active low |
| cs_mid_n | output | 4 | Middle sub-block selects, active low |
| rdy_int | output | 1 | Internal ready pulse to the bus controller |
| lat_a1 | output | 1 | Latched address bit 1 |
| lat_a2 | output | 1 | Latched address bit 2 |

## Verification
Each cycle is checked from the strobe to the ready pulse, so faults in internal state show up at the ports within that one cycle:
- A wrong size mask shows up as a select on the wrong side of a region edge, and a bad sub-block index lowers the wrong bit of `cs_mid_n`.
- A wait counter that loads or decrements wrongly moves `rdy_int` by a clock. The scoreboard catches this because it compares the count of select-low clocks before ready.
- A state machine that accepts a stray strobe shows up as changed latched bits or a second select pattern.
- A reset value that is off is visible on the first fetch from FFFF0h.

// File: rtl/memcs_pkg.sv
package memcs_pkg;

    localparam int ADDR_W = 20;
    localparam int GRAN_W = 10;
    localparam int SZ_W   = 3;
    localparam int WS_W   = 2;
    localparam int NMID   = 4;

    typedef struct packed {
        logic            ext;
        logic [WS_W-1:0] ws;
        logic [SZ_W-1:0] size;
        logic            en;
    } region_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_DONE = 2'd2
    } cyc_state_t;

    localparam region_cfg_t TOP_RESET = '{ext: 1'b1, ws: 2'd3, size: '0, en: 1'b1};
    localparam region_cfg_t OFF_RESET = '{ext: 1'b0, ws: '0, size: '0, en: 1'b0};

endpackage

// File: rtl/memcs_regs.sv
module memcs_regs
    import memcs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        waddr,
    input  logic [DATA_W-1:0] wdata,
    output region_cfg_t       top_cfg,
    output region_cfg_t       bot_cfg,
    output region_cfg_t       mid_cfg,
    output logic [BASE_W-1:0] mid_base
);

    localparam int CFG_W = $bits(region_cfg_t);

    region_cfg_t new_cfg;
    assign new_cfg = region_cfg_t'(wdata[CFG_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_cfg  <= TOP_RESET;
            bot_cfg  <= OFF_RESET;
            mid_cfg  <= OFF_RESET;
            mid_base <= '0;
        end else if (we) begin
            unique case (waddr)
                2'd0: top_cfg  <= new_cfg;
                2'd1: bot_cfg  <= new_cfg;
                2'd2: mid_cfg  <= new_cfg;
                2'd3: mid_base <= wdata[BASE_W-1:0];
            endcase
        end
    end

    // R1: the top region is on after reset, the others are off
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (top_cfg.en && top_cfg.ws == 2'd3 && !bot_cfg.en && !mid_cfg.en));

endmodule

// File: rtl/memcs_decode.sv
module memcs_decode
    import memcs_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int GW     = GRAN_W,
    parameter int NM     = NMID,
    parameter int BASE_W = 8
) (
    input  logic [AW-1:0]     addr,
    input  region_cfg_t       top_cfg,
    input  region_cfg_t       bot_cfg,
    input  region_cfg_t       mid_cfg,
    input  logic [BASE_W-1:0] mid_base,
    output logic [NM+1:0]     sel,
    output logic [WS_W-1:0]   sel_ws,
    output logic              sel_ext
);

    localparam int IDX_W = $clog2(NM);

    function automatic logic [AW-1:0] upper_mask(input int unsigned lo);
        logic [AW-1:0] m;
        for (int i = 0; i < AW; i++) m[i] = (i >= int'(lo));
        return m;
    endfunction

    logic [AW-1:0]    top_m, bot_m, mid_m, base_full;
    logic             top_hit, bot_hit, mid_hit;
    logic [IDX_W-1:0] mid_idx;
    logic [NM-1:0]    mid_sel;

    always_comb begin
        top_m     = upper_mask(GW + int'(top_cfg.size));
        bot_m     = upper_mask(GW + int'(bot_cfg.size));
        mid_m     = upper_mask(GW + IDX_W + int'(mid_cfg.size));
        base_full = {mid_base, {(AW-BASE_W){1'b0}}};
        top_hit   = top_cfg.en && ((addr & top_m) == top_m);
        bot_hit   = bot_cfg.en && ((addr & bot_m) == '0);
        mid_hit   = mid_cfg.en && (((addr ^ base_full) & mid_m) == '0);
        mid_idx   = IDX_W'(addr >> (GW + int'(mid_cfg.size)));
    end

    for (genvar g = 0; g < NM; g++) begin : g_mid
        assign mid_sel[g] = mid_hit && !top_hit && !bot_hit && (mid_idx == IDX_W'(g));
    end

    assign sel = {top_hit, bot_hit && !top_hit, mid_sel};

    always_comb begin
        if (top_hit) begin
            sel_ws = top_cfg.ws;  sel_ext = top_cfg.ext;
        end else if (bot_hit) begin
            sel_ws = bot_cfg.ws;  sel_ext = bot_cfg.ext;
        end else begin
            sel_ws = mid_cfg.ws;  sel_ext = mid_cfg.ext;
        end
    end

    // R5: the priority chain yields at most one hit
    always_comb begin
        if (!$isunknown(sel))
            a_r5_decode_onehot: assert ($onehot0(sel));
    end

endmodule

// File: rtl/memcs_cycle_fsm.sv
module memcs_cycle_fsm
    import memcs_pkg::*;
#(
    parameter int NSEL = NMID + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic            mem_cycle,
    input  logic [NSEL-1:0] hit,
    input  logic [WS_W-1:0] hit_ws,
    input  logic            hit_ext,
    input  logic            ext_rdy,
    input  logic [1:0]      addr_lo,
    output logic [NSEL-1:0] cs_n,
    output logic            rdy,
    output logic [1:0]      la
);

    cyc_state_t      state_q, state_d;
    logic [NSEL-1:0] sel_q;
    logic [WS_W-1:0] cnt_q;
    logic            ext_q;
    logic            start;

    assign start = ale && mem_cycle && (hit != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_WAIT;
            S_WAIT: if (cnt_q == '0 && (!ext_q || ext_rdy)) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= '0;
            cnt_q   <= '0;
            ext_q   <= 1'b0;
            la      <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                if (ale) la <= addr_lo;
                if (start) begin
                    sel_q <= hit;
                    cnt_q <= hit_ws;
                    ext_q <= hit_ext;
                end
            end else if (state_q == S_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        cs_n = (state_q == S_IDLE) ? '1 : ~sel_q;
        rdy  = (state_q == S_DONE);
    end

    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r6_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);
    a_r6_ready_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (cs_n != '1));
    a_r7_wait_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && ext_q && !ext_rdy) |=> !rdy);
    a_r9_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |=> $stable(cs_n));
    a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(la));

endmodule

// File: rtl/memcs_wait_unit.sv
module memcs_wait_unit
    import memcs_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ale,
    input  logic              mem_cycle,
    input  logic [AW-1:0]     bus_addr,
    input  logic              ext_rdy,
    output logic              cs_top_n,
    output logic              cs_bot_n,
    output logic [NMID-1:0]   cs_mid_n,
    output logic              rdy_int,
    output logic              lat_a1,
    output logic              lat_a2
);

    localparam int BASE_W = AW - GRAN_W - $clog2(NMID);
    localparam int NSEL   = NMID + 2;

    region_cfg_t       top_cfg, bot_cfg, mid_cfg;
    logic [BASE_W-1:0] mid_base;
    logic [NSEL-1:0]   hit, cs_vec_n;
    logic [WS_W-1:0]   hit_ws;
    logic              hit_ext;
    logic [1:0]        la;

    memcs_regs #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .top_cfg(top_cfg), .bot_cfg(bot_cfg), .mid_cfg(mid_cfg), .mid_base(mid_base)
    );

    memcs_decode #(.AW(AW), .GW(GRAN_W), .NM(NMID), .BASE_W(BASE_W)) u_decode (
        .addr(bus_addr), .top_cfg(top_cfg), .bot_cfg(bot_cfg), .mid_cfg(mid_cfg),
        .mid_base(mid_base), .sel(hit), .sel_ws(hit_ws), .sel_ext(hit_ext)
    );

    memcs_cycle_fsm #(.NSEL(NSEL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ale(ale), .mem_cycle(mem_cycle), .hit(hit),
        .hit_ws(hit_ws), .hit_ext(hit_ext), .ext_rdy(ext_rdy), .addr_lo(bus_addr[2:1]),
        .cs_n(cs_vec_n), .rdy(rdy_int), .la(la)
    );

    assign cs_top_n = cs_vec_n[NSEL-1];
    assign cs_bot_n = cs_vec_n[NSEL-2];
    assign cs_mid_n = cs_vec_n[NMID-1:0];
    assign lat_a1   = la[0];
    assign lat_a2   = la[1];

    // R8: a ready pulse always belongs to a select that is low
    a_r8_no_stray_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_int |-> !(cs_top_n && cs_bot_n && (&cs_mid_n)));

endmodule

// File: tb/memcs_wait_unit_bench.sv
module memcs_wait_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        ale = 1'b0;
    logic        mem_cycle = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        ext_rdy = 1'b1;
    logic        cs_top_n, cs_bot_n, rdy_int, lat_a1, lat_a2;
    logic [3:0]  cs_mid_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    memcs_wait_unit u_memcs_wait_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ale(ale), .mem_cycle(mem_cycle), .bus_addr(bus_addr),
        .ext_rdy(ext_rdy), .cs_top_n(cs_top_n), .cs_bot_n(cs_bot_n),
        .cs_mid_n(cs_mid_n), .rdy_int(rdy_int), .lat_a1(lat_a1), .lat_a2(lat_a2)
    );

    typedef struct {
        logic [5:0] pat;
        int         cnt;
        logic [1:0] la;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;

    function automatic logic [5:0] active_pat();
        return ~{cs_top_n, cs_bot_n, cs_mid_n};
    endfunction

    // monitor: measure each open cycle and compare with the queue head
    logic [5:0] m_pat;
    logic [1:0] m_la;
    int         m_cnt = 0;
    logic       m_open = 1'b0;

    always @(negedge clk) begin
        if (rst_n && active_pat() != '0) begin
            if (!m_open) begin
                m_open = 1'b1; m_cnt = 0; m_pat = active_pat(); m_la = {lat_a2, lat_a1};
            end
            if (rdy_int) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8: unexpected cycle pat=%b cnt=%0d expected none", m_pat, m_cnt);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.pat !== m_pat || e.cnt != m_cnt || e.la !== m_la) begin
                        n_fail++;
                        $display("FAIL %s: pat=%b cnt=%0d la=%b expected pat=%b cnt=%0d la=%b",
                                 e.req, m_pat, m_cnt, m_la, e.pat, e.cnt, e.la);
                    end
                end
            end else if (m_pat !== active_pat()) begin
                n_checks++; n_fail++;
                $display("FAIL R9: select changed mid-cycle %b expected %b", active_pat(), m_pat);
            end else begin
                m_cnt++;
            end
        end else begin
            m_open = 1'b0;
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit en, input int sz, input int ws, input bit ext);
        return {1'b0, ext, 2'(ws), 3'(sz), en};
    endfunction

    // driver: one bus cycle; hit=0 means no select and no ready are expected
    task automatic bus_cycle(input logic [19:0] a, input bit mem, input bit hit,
                             input logic [5:0] pat, input int cnt, input int low_edges,
                             input bit stray, input string req);
        bit seen;
        seen = 1'b0;
        if (hit) exp_q.push_back('{pat: pat, cnt: cnt, la: a[2:1], req: req});
        @(negedge clk);
        ale = 1'b1; bus_addr = a; mem_cycle = mem;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            ale = stray && c == 0;
            if (stray && c == 0) bus_addr = a ^ 20'h00006;
            ext_rdy = (c >= low_edges);
            if (active_pat() != '0 || rdy_int) seen = 1'b1;
            if (active_pat() == '0 && c > 0) break;
        end
        ale = 1'b0; ext_rdy = 1'b1;
        if (!hit) begin
            n_checks++;
            if (seen) begin
                n_fail++;
                $display("FAIL %s: addr=%h select or ready seen, expected none", req, a);
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        if (active_pat() != '0 || rdy_int !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pat=%b rdy=%b expected pat=000000 rdy=0", active_pat(), rdy_int);
        end
        // R1/R2: reset fetch, 3 waits, external ready already high
        bus_cycle(20'hFFFF0, 1, 1, 6'b100000, 4, 0, 0, "R1");
        bus_cycle(20'hFFC02, 1, 1, 6'b100000, 4, 0, 0, "R2");
        bus_cycle(20'hFFBFE, 1, 0, '0, 0, 0, 0, "R2");
        bus_cycle(20'h00010, 1, 0, '0, 0, 0, 0, "R1");
        bus_cycle(20'hFFFF0, 0, 0, '0, 0, 0, 0, "R8");
        // R7: ext low for 5 edges outlasts 3 waits
        bus_cycle(20'hFFFF4, 1, 1, 6'b100000, 6, 5, 0, "R7");
        // R3 bottom: 4 KB, 1 wait, ext ignored even when low
        cfg_write(2'd1, ctl(1, 2, 1, 0));
        bus_cycle(20'h00FFE, 1, 1, 6'b010000, 2, 9, 0, "R3");
        bus_cycle(20'h01000, 1, 0, '0, 0, 0, 0, "R3");
        // R4 middle: 4 KB at 80000h, no waits, ext required
        cfg_write(2'd3, 8'h80);
        cfg_write(2'd2, ctl(1, 0, 0, 1));
        bus_cycle(20'h80000, 1, 1, 6'b000001, 1, 0, 0, "R4");
        bus_cycle(20'h80402, 1, 1, 6'b000010, 1, 0, 0, "R4");
        bus_cycle(20'h80804, 1, 1, 6'b000100, 4, 3, 0, "R7");
        bus_cycle(20'h80C06, 1, 1, 6'b001000, 1, 0, 0, "R4");
        bus_cycle(20'h81000, 1, 0, '0, 0, 0, 0, "R4");
        // R4 larger sub-blocks: size code 1 gives 2 KB each
        cfg_write(2'd2, ctl(1, 1, 2, 0));
        bus_cycle(20'h81802, 1, 1, 6'b001000, 3, 0, 0, "R4");
        // R6 top 128 KB, no waits, ext ignored
        cfg_write(2'd0, ctl(1, 7, 0, 0));
        bus_cycle(20'hE0000, 1, 1, 6'b100000, 1, 4, 0, "R6");
        // R5 overlap: middle moved under the top region
        cfg_write(2'd3, 8'hF0);
        bus_cycle(20'hF0006, 1, 1, 6'b100000, 1, 0, 0, "R5");
        // R9: stray strobe during an open cycle is ignored
        cfg_write(2'd0, ctl(1, 7, 2, 0));
        bus_cycle(20'hE0002, 1, 1, 6'b100000, 3, 0, 1, "R9");
        n_checks++;
        if ({lat_a2, lat_a1} !== 2'b01) begin
            n_fail++;
            $display("FAIL R10: latched=%b expected 01", {lat_a2, lat_a1});
        end
        // R10: I/O cycle still latches address bits
        bus_cycle(20'h00004, 0, 0, '0, 0, 0, 0, "R8");
        n_checks++;
        if ({lat_a2, lat_a1} !== 2'b10) begin
            n_fail++;
            $display("FAIL R10: latched=%b expected 10", {lat_a2, lat_a1});
        end
        // R11: disabling the top region removes its select
        cfg_write(2'd0, ctl(0, 7, 0, 0));
        bus_cycle(20'hFFFF0, 1, 0, '0, 0, 0, 0, "R11");
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6: %0d expected cycles never completed, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule